// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is a register-mapped controller for up to 32 general-purpose I/O lines, organised as four 8-bit ports (A to D) on a simple 32-bit register bus. Software sets the direction and the output level of each line, and reads back either the driven value or the sampled pin level. Every input passes through a two-flop synchroniser. A per-line 2-bit mode field selects falling, rising or both edges, and also acts as the interrupt enable. Detected edges latch into status bits, which software clears by writing ones.

A summary interrupt is raised while any status bit is set. A second register region holds one 32-bit enable mask per CPU, and each CPU gets its own interrupt output. The `REVERSED` parameter chooses the byte order of the four ports inside every register. This order must match what software expects, so the interrupt source and the status bit always agree.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register in the main region reads zero, every per-CPU mask reads all ones for the implemented lines, and `pin_oe`, `pin_out`, `irq_any` and `irq_cpu` are low.
- R2: The direction word (byte offset 0x08) and the data word (0x0C) drive the pins. A direction bit of 1 makes a line an output, so `pin_oe` equals the direction bits and `pin_out` equals the written data bits. Both words read back as written.
- R3: A read of the data word returns the written value for output lines and the synchronised pin level for input lines.
- R4: With `REVERSED`=0, line n (port p = n/8, pin i = n%8) occupies bit 8*(3-p)+i of every one-bit-per-line word, so port A is the most significant byte.
- R5: With `REVERSED`=1, line n occupies bit n of every one-bit-per-line word.
- R6: The mode codes are 0 off, 1 falling edge, 2 rising edge and 3 both edges. A status bit is set only by an edge of a type that the line's code selects.
- R7: The mode fields span two words, at 0x14 (bits 0-31 of a 64-bit field vector) and 0x18 (bits 32-63). Line n's field starts at bit 2*(8*(p XOR 1)+i) when `REVERSED`=0 and at bit 2n when `REVERSED`=1.
- R8: A write to the status word (0x10) clears each bit written as 1 and leaves each bit written as 0. An edge that sets a bit in the same cycle as its clear wins, and the bit stays set.
- R9: `irq_any` is the OR of all status bits. `irq_cpu[k]` is the OR of the status bits ANDed with CPU k's mask. The masks sit in the second region (`bus_region`=1) at byte offset 4*k, with the same bit packing as the status word.
- R10: The pin-select word at 0x00 is plain read/write storage and has no effect on `pin_oe` or `pin_out`.
- R11: Consider a pin change applied between two clock edges. The status bit it sets becomes readable after the third rising clock edge that follows the change, and is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_region | input | 1 | 0 = main registers, 1 = per-CPU masks |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | NLINES | Pad input levels |
| pin_out | output | NLINES | Pad output levels |
| pin_oe | output | NLINES | Pad output enables |
| irq_any | output | 1 | Summary interrupt |
| irq_cpu | output | NCPU | Per-CPU interrupt outputs |

## Verification
Two instances share one bus, one with each port order. Every single-bit pattern written to direction and data therefore shows both packings at the pins at the same time. Each mode code is placed in turn on lines from all four ports, and all pins are then toggled up and down. The expected status words, computed from the field placement formula, tell a misplaced field apart from a wrong edge decode. Partial write-one-to-clear masks, a clear that lands in the same cycle as an edge, and split per-CPU masks separate the clear priority and the routing from the plain OR.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NLINES   = 32,
  parameter int NCPU     = 2,
  parameter bit REVERSED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_region,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_any,
  output logic [NCPU-1:0]   irq_cpu
);

  function automatic logic [63:0] mode_mask_f();
    logic [63:0] r = '0;
    for (int n = 0; n < 32; n++)
      if (n < NLINES) r[2*n +: 2] = 2'b11;
    return r;
  endfunction

  localparam logic [31:0] LMASK = 32'((64'd1 << NLINES) - 64'd1);
  localparam logic [63:0] MMASK = mode_mask_f();

  function automatic logic [31:0] ord1(logic [31:0] v);
    return REVERSED ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [63:0] ord2(logic [63:0] v);
    return REVERSED ? v : {v[47:32], v[63:48], v[15:0], v[31:16]};
  endfunction

  logic [31:0] psel_q, dir_q, dout_q, stat_q;
  logic [63:0] mode_q;
  logic [31:0] mask_q [NCPU];
  logic [31:0] s1, s2, s3;

  logic [31:0] pin32, rise, fall, hit, clr, mode_en, rd_val;
  logic [63:0] mcur;
  logic        acc_ok, wmain, wr_data, wr_dir;
  logic [2:0]  widx;
  logic [NCPU-1:0] wcpu;

  assign pin32   = 32'(pin_in);
  assign acc_ok  = bus_en && bus_addr[1:0] == 2'b00;
  assign widx    = bus_addr[4:2];
  assign wmain   = acc_ok && bus_we && !bus_region && bus_addr[7:5] == 3'd0;
  assign wr_dir  = wmain && widx == 3'd2;
  assign wr_data = wmain && widx == 3'd3;
  assign rise    = s2 & ~s3;
  assign fall    = ~s2 & s3;
  assign clr     = (wmain && widx == 3'd4) ? ord1(bus_wdata) : '0;
  assign mcur    = ord2(mode_q);
  assign rd_val  = (dir_q & dout_q) | (~dir_q & s2);

  always_comb begin
    for (int n = 0; n < 32; n++) begin
      hit[n]     = (mode_q[2*n+1] & rise[n]) | (mode_q[2*n] & fall[n]);
      mode_en[n] = |mode_q[2*n +: 2];
    end
    for (int k = 0; k < NCPU; k++)
      wcpu[k] = acc_ok && bus_we && bus_region && bus_addr[7:2] == 6'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel_q <= '0; dir_q <= '0; dout_q <= '0; stat_q <= '0; mode_q <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      for (int k = 0; k < NCPU; k++) mask_q[k] <= LMASK;
    end else begin
      s1 <= pin32;
      s2 <= s1;
      s3 <= s2;
      stat_q <= ((stat_q & ~clr) | hit) & LMASK;
      if (wmain) begin
        case (widx)
          3'd0: psel_q <= bus_wdata;
          3'd2: dir_q  <= ord1(bus_wdata) & LMASK;
          3'd3: dout_q <= ord1(bus_wdata) & LMASK;
          3'd5: mode_q <= ord2({mcur[63:32], bus_wdata}) & MMASK;
          3'd6: mode_q <= ord2({bus_wdata, mcur[31:0]}) & MMASK;
          default: ;
        endcase
      end
      for (int k = 0; k < NCPU; k++)
        if (wcpu[k]) mask_q[k] <= ord1(bus_wdata) & LMASK;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_region) begin
      case (bus_addr[7:2])
        6'd0: bus_rdata = psel_q;
        6'd2: bus_rdata = ord1(dir_q);
        6'd3: bus_rdata = ord1(rd_val);
        6'd4: bus_rdata = ord1(stat_q);
        6'd5: bus_rdata = mcur[31:0];
        6'd6: bus_rdata = mcur[63:32];
        default: ;
      endcase
    end else if (acc_ok) begin
      for (int k = 0; k < NCPU; k++)
        if (bus_addr[7:2] == 6'(k)) bus_rdata = ord1(mask_q[k]);
    end
  end

  assign pin_out = dout_q[NLINES-1:0];
  assign pin_oe  = dir_q[NLINES-1:0];
  assign irq_any = |stat_q;

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    assign irq_cpu[k] = |(stat_q & mask_q[k]);
  end

  // R6
  stat_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ~$past(stat_q))) |-> (|$past(mode_en)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_data) |-> $stable(pin_out));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir) |-> $stable(pin_oe));

  // R9
  cpu_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_cpu) |-> irq_any);

endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_region = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rdata0, rdata1, out0, out1, oe0, oe1;
  logic any0, any1;
  logic [1:0] cpu0, cpu1;
  logic [31:0] r0, r1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_bank #(.NLINES(32), .NCPU(2), .REVERSED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_region(bus_region),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pin_in(pins),
    .pin_out(out0), .pin_oe(oe0), .irq_any(any0), .irq_cpu(cpu0));

  gpio_edge_bank #(.NLINES(32), .NCPU(2), .REVERSED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_region(bus_region),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pin_in(pins),
    .pin_out(out1), .pin_oe(oe1), .irq_any(any1), .irq_cpu(cpu1));

  function automatic logic [31:0] pk(logic [31:0] v, bit rev);
    return rev ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic int fpos(int n, bit rev);
    return rev ? 2 * n : 2 * (8 * ((n / 8) ^ 1) + n % 8);
  endfunction

  function automatic logic [31:0] exp_stat(logic [63:0] m, bit rev, bit rising);
    logic [31:0] l = '0;
    for (int n = 0; n < 32; n++) begin
      logic [1:0] c;
      c = m[fpos(n, rev) +: 2];
      l[n] = rising ? c[1] : c[0];
    end
    return pk(l, rev);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit reg_sel, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_region = reg_sel; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(bit reg_sel, logic [7:0] a);
    bus_en = 1'b1; bus_we = 1'b0; bus_region = reg_sel; bus_addr = a;
    #1;
    r0 = rdata0; r1 = rdata1;
    bus_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lines[5] = '{0, 5, 9, 17, 30};
    logic [31:0] ev0, ev1, keep_o, keep_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(1'b0, 8'(4 * a));
      chk("R1 main reg u0", r0, 32'h0);
      chk("R1 main reg u1", r1, 32'h0);
    end
    for (int k = 0; k < 2; k++) begin
      rd(1'b1, 8'(4 * k));
      chk("R1 cpu mask u0", r0, 32'hFFFF_FFFF);
      chk("R1 cpu mask u1", r1, 32'hFFFF_FFFF);
    end
    chk("R1 outputs", {oe0 | oe1 | out0 | out1}, 32'h0);
    chk("R1 irqs", {28'h0, cpu0, any0, any1}, 32'h0);

    // R2 R4 R5 single-bit sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = 32'h1 << i;
      wr(1'b0, 8'h08, w);
      wr(1'b0, 8'h0C, ~w);
      chk("R4 oe normal order", oe0, pk(w, 1'b0));
      chk("R5 oe reversed order", oe1, w);
      chk("R4 out normal order", out0, pk(~w, 1'b0));
      chk("R5 out reversed order", out1, ~w);
      rd(1'b0, 8'h08);
      chk("R2 dir readback u0", r0, w);
      chk("R2 dir readback u1", r1, w);
    end

    // R3 data readback mix
    wr(1'b0, 8'h08, 32'h00FF_0F0F);
    wr(1'b0, 8'h0C, 32'hA5C3_3C5A);
    pins = 32'h1234_5678;
    settle();
    rd(1'b0, 8'h0C);
    chk("R3 data read u0", r0, (32'h00FF_0F0F & 32'hA5C3_3C5A) | (~32'h00FF_0F0F & pk(pins, 1'b0)));
    chk("R3 data read u1", r1, (32'h00FF_0F0F & 32'hA5C3_3C5A) | (~32'h00FF_0F0F & pins));
    pins = '0;
    settle();

    // R10 pin select has no effect
    keep_o = out0; keep_e = oe0;
    wr(1'b0, 8'h00, 32'hA5A5_A5A5);
    rd(1'b0, 8'h00);
    chk("R10 psel readback u0", r0, 32'hA5A5_A5A5);
    chk("R10 psel readback u1", r1, 32'hA5A5_A5A5);
    chk("R10 out unaffected", out0, keep_o);
    chk("R10 oe unaffected", oe0, keep_e);

    // R6 R7 mode code and placement sweep
    for (int c = 0; c < 4; c++) begin
      foreach (lines[j]) begin
        logic [63:0] m;
        m = 64'(c) << fpos(lines[j], 1'b0);
        wr(1'b0, 8'h14, m[31:0]);
        wr(1'b0, 8'h18, m[63:32]);
        rd(1'b0, 8'h14);
        chk("R7 mode readback", r0, m[31:0]);
        wr(1'b0, 8'h10, 32'hFFFF_FFFF);
        pins = 32'hFFFF_FFFF;
        settle();
        rd(1'b0, 8'h10);
        ev0 = exp_stat(m, 1'b0, 1'b1);
        ev1 = exp_stat(m, 1'b1, 1'b1);
        chk("R6 R7 rising status u0", r0, ev0);
        chk("R6 R7 rising status u1", r1, ev1);
        pins = 32'h0;
        settle();
        rd(1'b0, 8'h10);
        ev0 |= exp_stat(m, 1'b0, 1'b0);
        ev1 |= exp_stat(m, 1'b1, 1'b0);
        chk("R6 R7 falling status u0", r0, ev0);
        chk("R6 R7 falling status u1", r1, ev1);
        chk("R9 irq_any follows status", {30'h0, any0, any1}, {30'h0, ev0 != 0, ev1 != 0});
      end
    end

    // R11 latency
    wr(1'b0, 8'h14, 32'hFFFF_FFFF);
    wr(1'b0, 8'h18, 32'hFFFF_FFFF);
    wr(1'b0, 8'h10, 32'hFFFF_FFFF);
    pins = 32'h0000_0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(1'b0, 8'h10);
    chk("R11 not yet after two edges", r1, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rd(1'b0, 8'h10);
    chk("R11 set after third edge", r1, 32'h0000_0001);

    // R8 partial clear
    pins = 32'hFFFF_FFFF;
    settle();
    rd(1'b0, 8'h10);
    chk("R8 all set u0", r0, 32'hFFFF_FFFF);
    wr(1'b0, 8'h10, 32'h0000_FF00);
    rd(1'b0, 8'h10);
    chk("R8 partial clear u0", r0, 32'hFFFF_00FF);
    chk("R8 partial clear u1", r1, 32'hFFFF_00FF);
    wr(1'b0, 8'h10, 32'h0);
    rd(1'b0, 8'h10);
    chk("R8 zero write keeps u0", r0, 32'hFFFF_00FF);

    // R8 edge wins over same-cycle clear
    @(negedge clk);
    pins = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_region = 1'b0; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(1'b0, 8'h10);
    chk("R8 collision keeps u0", r0, 32'hFFFF_FFFF);
    chk("R8 collision keeps u1", r1, 32'hFFFF_FFFF);
    settle();

    // R9 per-CPU routing
    wr(1'b1, 8'h00, 32'h0000_00FF);
    wr(1'b1, 8'h04, 32'hFF00_0000);
    rd(1'b1, 8'h00);
    chk("R9 mask0 readback", r0, 32'h0000_00FF);
    rd(1'b1, 8'h04);
    chk("R9 mask1 readback", r1, 32'hFF00_0000);
    chk("R9 both cpus on", {28'h0, cpu0, cpu1}, 32'hF);
    wr(1'b0, 8'h10, 32'hFFFF_FF00);
    chk("R9 cpu0 only u0", {30'h0, cpu0}, 32'h1);
    chk("R9 cpu0 only u1", {30'h0, cpu1}, 32'h1);
    chk("R9 any still on", {30'h0, any0, any1}, 32'h3);
    wr(1'b0, 8'h10, 32'hFFFF_FFFF);
    chk("R9 all off", {28'h0, cpu0, cpu1}, 32'h0);
    chk("R9 any off", {30'h0, any0, any1}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule